// File: doc/BRIEF.md
# Strobe-gated pixel hit matrix with sparse readout

The block holds one hit latch per pixel of a ROWS x COLS matrix. A single acquisition window, the global strobe, is shared by all pixels. A pixel records a hit only when its discriminator input is high in a cycle in which the strobe is open. A digital test pulse does the same for selected pixels, so the capture and readout path can be exercised without any analogue signal. Once set, a latch holds its hit after the discriminator drops. It keeps the hit until that pixel is read out.

The strobe is produced inside the block. A start pulse opens it. In short mode it closes by itself after a programmed number of cycles. In long mode it stays open until a stop pulse arrives.

Readout begins only when a command is given. A priority encoder then drains the latched pixels one beat at a time on a valid/ready stream. Each beat carries the pixel's row and column address, and each pixel's latch is cleared as its address is accepted. After the last address, a single end-of-frame beat carries the number of hits that were sent.

While a readout is in progress, the block ignores strobe start pulses. It drops any further readout command and flags it. A command that arrives while the strobe is still open is held until the strobe closes.

Top module: `pixel_hit_readout`

## Requirements
- R1: A pixel latch is set only at a clock edge where strobe_o is high and either disc_i[i] is high or both pulse_i and pulse_sel_i[i] are high. Pixel index i = row*COLS + col. A discriminator pulse outside the window leaves no hit, and an open window with no discriminator or pulse leaves no hit.
- R2: A set latch stays set after its discriminator input falls, until that pixel is read out.
- R3: The output stream stays idle (out_valid_o low) until readout_i is asserted, however many hits are latched.
- R4: Hit addresses are emitted in ascending pixel index: lowest row first, then lowest column within the row. An address beat has out_data_o[COL_W-1:0] = column, out_data_o[ROW_W+COL_W-1:COL_W] = row and the upper bits zero, with out_eof_o low. Pixels without a hit produce no beat.
- R5: A beat is transferred on a cycle with out_valid_o and out_ready_i both high. While out_ready_i is low, out_valid_o, out_data_o and out_eof_o hold their values.
- R6: After the last address, one beat is sent with out_eof_o high and out_data_o equal to the number of address beats in the frame. After that beat, every latch is clear, so a following readout with no new hits yields only an end-of-frame beat with count 0.
- R7: With pulse_i high during an open window, exactly the pixels selected by pulse_sel_i are recorded as hits.
- R8: In short mode (strobe_long_i low when the start is taken), strobe_o rises in the cycle after a strobe_start_i pulse is sampled. It stays high for strobe_len_i cycles, or for one cycle when strobe_len_i is 0.
- R9: In long mode (strobe_long_i high when the start is taken), strobe_o stays high until the edge at which strobe_stop_i is sampled high.
- R10: A strobe_start_i pulse is ignored while a readout is pending or in progress. A start pulse in the same cycle as a readout command is also ignored. An ignored start opens no window and records no hits.
- R11: A readout command that arrives while a readout is pending or active is dropped. err_o is high for the one cycle after that command, and no extra frame follows.
- R12: A readout command that arrives while strobe_o is high waits until the strobe closes. No beat appears while the window is open, and hits recorded later in that same window are included in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_start_i | input | 1 | Opens the acquisition window |
| strobe_stop_i | input | 1 | Closes a long-mode window |
| strobe_long_i | input | 1 | Selects long mode for the next window |
| strobe_len_i | input | LEN_W | Short-mode window length in cycles |
| strobe_o | output | 1 | Global strobe seen by all pixels |
| disc_i | input | ROWS*COLS | Per-pixel discriminator outputs |
| pulse_i | input | 1 | Digital test pulse |
| pulse_sel_i | input | ROWS*COLS | Pixels that the test pulse reaches |
| readout_i | input | 1 | Readout command |
| out_valid_o | output | 1 | Stream beat valid |
| out_ready_i | input | 1 | Stream sink ready |
| out_data_o | output | DW | {row, column} address, or hit count on the end-of-frame beat |
| out_eof_o | output | 1 | Marks the end-of-frame beat |
| err_o | output | 1 | One-cycle flag for a dropped readout command |

## Verification
A latch that was never set, or never cleared, shows up in the next frame. It either leaves an address out or emits a stray address, and the end-of-frame count is then off. At the latest, the following empty readout reports a nonzero count. A fault in the priority order or the address packing shows at once as a wrong address or a wrong sequence on the first multi-hit frame. A strobe counter that is off by one changes the measured window width in the cycle it closes. A readout state that fails to block starts or commands shows up within a few cycles: as a strobe pulse during readout, a missing err_o, or hits captured that should have been refused.

// File: rtl/pix_pkg.sv
// Shared types for the pixel hit matrix readout.
// Assumes nothing beyond being compiled before the modules that import it.
package pix_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,   // no readout pending
        RD_WAIT = 2'd1,   // command taken, waiting for the strobe to close
        RD_SCAN = 2'd2,   // emitting hit addresses
        RD_EOF  = 2'd3    // emitting the end-of-frame beat
    } rd_state_t;
endpackage

// File: rtl/pix_strobe_gen.sv
// Acquisition window generator: start opens the window. Short mode closes it
// after len cycles (0 counts as 1); long mode closes it on a stop pulse.
// Assumes block_i is high whenever a start must be refused.
module pix_strobe_gen #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             long_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             block_i,
    output logic             strobe_o
);
    logic             open_q;
    logic             long_q;
    logic [LEN_W-1:0] cnt_q;

    // Window state: open, mode captured at open, remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            long_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!open_q) begin
            if (start_i && !block_i) begin
                open_q <= 1'b1;
                long_q <= long_i;
                cnt_q  <= (len_i == '0) ? LEN_W'(1) : len_i;
            end
        end else if (long_q) begin
            if (stop_i) open_q <= 1'b0;
        end else begin
            if (cnt_q <= LEN_W'(1)) open_q <= 1'b0;
            else                    cnt_q  <= cnt_q - LEN_W'(1);
        end
    end

    assign strobe_o = open_q;

    // R8: a window only opens after a start request
    p_open_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> $past(start_i));

    // R10: a blocked start never opens a closed window
    p_block_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_o && block_i) |=> !strobe_o);
endmodule

// File: rtl/pix_hit_array.sv
// Per-pixel hit latches. A latch sets when the strobe overlaps its
// discriminator or the selected digital pulse, and clears on its clear bit.
// Assumes at most one clear bit is set per cycle.
module pix_hit_array #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int N = ROWS * COLS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [N-1:0] disc_i,
    input  logic         pulse_i,
    input  logic [N-1:0] pulse_sel_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] hit_o
);
    logic [N-1:0] hit_q;

    for (genvar i = 0; i < N; i++) begin : g_pix
        // One hit latch: clear on readout, set on strobe overlap.
        always_ff @(posedge clk) begin
            if (!rst_n)                                             hit_q[i] <= 1'b0;
            else if (clr_i[i])                                      hit_q[i] <= 1'b0;
            else if (strobe_i && (disc_i[i] || (pulse_i && pulse_sel_i[i]))) hit_q[i] <= 1'b1;
        end

        // R1: a hit appears only after a cycle with the strobe open
        p_set_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hit_q[i]) |-> $past(strobe_i));
    end

    assign hit_o = hit_q;

    // R6: readout clears one pixel at a time
    p_clr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_i));
endmodule

// File: rtl/pix_prio_enc.sv
// Priority encoder: reports whether any request is set and the index of the
// lowest set request. Purely combinational.
module pix_prio_enc #(
    parameter int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Scan downwards so the lowest set index is the last one written.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pixel_hit_readout.sv
// Strobe-gated pixel hit matrix with sparse priority-encoded readout.
// On a readout command it drains latched pixels lowest index first as
// {row, col} beats, clears each one as it is accepted, and then sends an
// end-of-frame beat carrying the hit count. Assumes ROWS and COLS >= 2.
module pixel_hit_readout
    import pix_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int LEN_W = 8,
    localparam int N     = ROWS * COLS,
    localparam int IW    = $clog2(N),
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int AW    = ROW_W + COL_W,
    localparam int CNT_W = $clog2(N + 1),
    localparam int DW    = (AW > CNT_W) ? AW : CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_start_i,
    input  logic             strobe_stop_i,
    input  logic             strobe_long_i,
    input  logic [LEN_W-1:0] strobe_len_i,
    output logic             strobe_o,
    input  logic [N-1:0]     disc_i,
    input  logic             pulse_i,
    input  logic [N-1:0]     pulse_sel_i,
    input  logic             readout_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [DW-1:0]    out_data_o,
    output logic             out_eof_o,
    output logic             err_o
);
    rd_state_t        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             busy;
    logic             strobe;
    logic [N-1:0]     hits;
    logic [N-1:0]     clr;
    logic             any_hit;
    logic [IW-1:0]    idx;
    logic [IW-1:0]    row_full;
    logic [IW-1:0]    col_full;
    logic [AW-1:0]    addr;
    logic             take;

    assign busy = (state_q != RD_IDLE);

    pix_strobe_gen #(.LEN_W(LEN_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (strobe_start_i),
        .stop_i   (strobe_stop_i),
        .long_i   (strobe_long_i),
        .len_i    (strobe_len_i),
        .block_i  (busy || readout_i),
        .strobe_o (strobe)
    );

    pix_hit_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .disc_i      (disc_i),
        .pulse_i     (pulse_i),
        .pulse_sel_i (pulse_sel_i),
        .clr_i       (clr),
        .hit_o       (hits)
    );

    pix_prio_enc #(.N(N)) u_enc (
        .req_i (hits),
        .any_o (any_hit),
        .idx_o (idx)
    );

    // Split the pixel index into row and column fields.
    assign row_full = idx / IW'(COLS);
    assign col_full = idx % IW'(COLS);
    assign addr     = {row_full[ROW_W-1:0], col_full[COL_W-1:0]};

    // An address beat is accepted this cycle.
    assign take = (state_q == RD_SCAN) && any_hit && out_ready_i;

    for (genvar i = 0; i < N; i++) begin : g_clr
        assign clr[i] = take && (idx == IW'(i));
    end

    // Readout sequencing and the per-frame hit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (readout_i) state_q <= strobe ? RD_WAIT : RD_SCAN;
                RD_WAIT: if (!strobe)   state_q <= RD_SCAN;
                RD_SCAN: begin
                    if (!any_hit)  state_q <= RD_EOF;
                    else if (take) cnt_q   <= cnt_q + CNT_W'(1);
                end
                RD_EOF: if (out_ready_i) begin
                    state_q <= RD_IDLE;
                    cnt_q   <= '0;
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    // Flag a command that arrives while a readout is already underway.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= readout_i && busy;
    end

    assign strobe_o    = strobe;
    assign out_valid_o = ((state_q == RD_SCAN) && any_hit) || (state_q == RD_EOF);
    assign out_eof_o   = (state_q == RD_EOF);
    assign out_data_o  = (state_q == RD_EOF) ? DW'(cnt_q) : DW'(addr);
    assign err_o       = err_q;

    // R5: a stalled beat holds still
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
        (out_valid_o && $stable(out_data_o) && $stable(out_eof_o)));

    // R6: end of frame is only sent once the matrix has been drained
    p_eof_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof_o |-> !any_hit);

    // R10: no window is open while addresses are being drained
    p_no_strobe_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RD_SCAN) || (state_q == RD_EOF)) |-> !strobe);

    // R11: a command during readout raises the error flag next cycle
    p_err_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_i && busy) |=> err_o);

    // R12: no beat while the window is open
    p_wait_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !out_valid_o);
endmodule

// File: tb/pixel_hit_readout_test.sv
// Self-checking bench for pixel_hit_readout with an 8x8 matrix.
module pixel_hit_readout_test;
    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int LEN_W = 8;
    localparam int N     = ROWS * COLS;
    localparam int COL_W = $clog2(COLS);
    localparam int AW    = $clog2(ROWS) + COL_W;
    localparam int CNT_W = $clog2(N + 1);
    localparam int DW    = (AW > CNT_W) ? AW : CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0, stop = 1'b0, lng = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic             strobe_o;
    logic [N-1:0]     disc = '0, psel = '0;
    logic             pulse = 1'b0, readout = 1'b0, ready = 1'b1;
    logic             out_valid, out_eof, err_o;
    logic [DW-1:0]    out_data;

    int total = 0, fails = 0;
    bit finished = 0;
    logic [DW-1:0] got [0:N];
    int gotn, gotcnt;

    always #2.5 clk = ~clk;

    pixel_hit_readout #(.ROWS(ROWS), .COLS(COLS), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .strobe_start_i(start), .strobe_stop_i(stop), .strobe_long_i(lng),
        .strobe_len_i(len), .strobe_o(strobe_o),
        .disc_i(disc), .pulse_i(pulse), .pulse_sel_i(psel),
        .readout_i(readout), .out_valid_o(out_valid), .out_ready_i(ready),
        .out_data_o(out_data), .out_eof_o(out_eof), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Open a short window of len l with disc/pulse patterns applied.
    task automatic capture(input logic [N-1:0] d, input logic [N-1:0] ps,
                           input bit p, input int l);
        disc = d; psel = ps; pulse = p; len = LEN_W'(l); lng = 1'b0;
        start = 1'b1; step(); start = 1'b0;
        repeat (l + 1) step();
        disc = '0; pulse = 1'b0;
    endtask

    // Collect one frame; optionally send the command and stall the sink.
    task automatic run_readout(input bit send_cmd, input bit stall);
        logic [DW-1:0] hd;
        logic he;
        bit done;
        gotn = 0; gotcnt = -1;
        if (send_cmd) begin readout = 1'b1; step(); readout = 1'b0; end
        for (int c = 0; c < 400; c++) begin
            ready = !(stall && (c % 3 == 1));
            #0;
            if (out_valid && !ready) begin
                hd = out_data; he = out_eof;
                step();
                chk(out_valid && out_data == hd && out_eof == he, "R5 stall hold",
                    int'(out_data), int'(hd));
                continue;
            end
            done = out_valid && out_eof;
            if (out_valid) begin
                if (out_eof) gotcnt = int'(out_data);
                else if (gotn <= N) begin got[gotn] = out_data; gotn++; end
            end
            step();
            if (done) break;
        end
        ready = 1'b1;
    endtask

    // Compare the collected frame with the expected pattern.
    task automatic verify(input logic [N-1:0] pat, input string r);
        int k = 0, bad = 0, pc = 0;
        for (int i = 0; i < N; i++) begin
            if (pat[i]) begin
                int e = ((i / COLS) << COL_W) | (i % COLS);
                if (k >= gotn || int'(got[k]) != e) bad++;
                k++; pc++;
            end
        end
        chk(gotn == pc, {r, " beat count"}, gotn, pc);
        chk(bad == 0, {r, " R4 address order"}, bad, 0);
        chk(gotcnt == pc, {r, " R6 eof count"}, gotcnt, pc);
    endtask

    // Measure strobe width after a start; stop at sample index sa (-1 none).
    task automatic measure(input bit lm, input int l, input int sa, output int w,
                           output bit first);
        lng = lm; len = LEN_W'(l); start = 1'b1; step(); start = 1'b0;
        w = 0; first = strobe_o;
        for (int k = 0; k < 24; k++) begin
            if (strobe_o) w++;
            stop = (k == sa);
            step();
        end
        stop = 1'b0; lng = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] pat;
        int w;
        bit first;
        repeat (3) step();
        rst_n = 1'b1; step();
        chk(!out_valid && !strobe_o && !err_o, "reset idle", int'(out_valid), 0);

        // R3: hits held but no readout without a command
        capture(N'(64'h81), '0, 1'b0, 2);
        repeat (10) begin
            if (out_valid) chk(0, "R3 no spontaneous readout", 1, 0);
            step();
        end
        chk(!out_valid, "R3 idle with hits", int'(out_valid), 0);
        run_readout(1'b1, 1'b0);
        verify(N'(64'h81), "R3 R2");

        // R1 R2 R4 R6: exhaustive single-pixel sweep
        for (int p = 0; p < N; p++) begin
            pat = '0; pat[p] = 1'b1;
            capture(pat, '0, 1'b0, 1 + (p % 3));
            run_readout(1'b1, p[0]);
            verify(pat, "R1 single");
        end

        // R4 R5: varied multi-hit patterns, alternating stall
        for (int t = 0; t < 6; t++) begin
            pat = '0;
            for (int j = 0; j < N; j++)
                if (((j * (t + 3) + t * 7) % (t + 2)) == 0) pat[j] = 1'b1;
            capture(pat, '0, 1'b0, 3);
            run_readout(1'b1, t[0]);
            verify(pat, "R4 multi");
        end
        capture('1, '0, 1'b0, 1);
        run_readout(1'b1, 1'b1);
        verify('1, "R4 full");

        // R6: matrix empty after a frame
        run_readout(1'b1, 1'b0);
        verify('0, "R6 empty");

        // R1: disc outside window, and window without disc
        disc = '1; repeat (3) step(); disc = '0; step();
        capture('0, '1, 1'b0, 4);
        run_readout(1'b1, 1'b0);
        verify('0, "R1 no overlap");

        // R7: digital pulse on selected pixels
        pat = N'(64'hF0F0_0000_1234_8001);
        capture('0, pat, 1'b1, 2);
        run_readout(1'b1, 1'b0);
        verify(pat, "R7 pulse");

        // R8: short strobe widths
        for (int l = 0; l < 6; l++) begin
            measure(1'b0, l, -1, w, first);
            chk(first == 1'b1, "R8 opens next cycle", int'(first), 1);
            chk(w == ((l == 0) ? 1 : l), "R8 width", w, (l == 0) ? 1 : l);
        end

        // R9: long strobe held until stop
        measure(1'b1, 2, 6, w, first);
        chk(w == 7, "R9 long width", w, 7);

        // R10: start ignored during readout
        pat = N'(64'h0000_0100_0000_0042);
        capture(pat, '0, 1'b0, 2);
        readout = 1'b1; step(); readout = 1'b0;
        ready = 1'b0; disc = '1;
        start = 1'b1; len = LEN_W'(4); step(); start = 1'b0;
        chk(!strobe_o, "R10 start ignored", int'(strobe_o), 0);
        step(); disc = '0;
        run_readout(1'b0, 1'b0);
        verify(pat, "R10 frame");
        // R10: start with command in the same cycle is ignored
        disc = '1; start = 1'b1; readout = 1'b1; step();
        start = 1'b0; readout = 1'b0;
        chk(!strobe_o, "R10 start with cmd", int'(strobe_o), 0);
        run_readout(1'b0, 1'b0);
        disc = '0;
        verify('0, "R10 same cycle");

        // R11: second command dropped and flagged
        pat = N'(64'h8000_0000_0000_0300);
        capture(pat, '0, 1'b0, 1);
        readout = 1'b1; step(); ready = 1'b0; step(); readout = 1'b0;
        chk(err_o == 1'b1, "R11 err flag", int'(err_o), 1);
        step();
        chk(err_o == 1'b0, "R11 err one cycle", int'(err_o), 0);
        run_readout(1'b0, 1'b0);
        verify(pat, "R11 frame");
        run_readout(1'b1, 1'b0);
        verify('0, "R11 no extra frame");

        // R12: command during open window waits
        lng = 1'b1; start = 1'b1; step(); start = 1'b0; lng = 1'b0;
        step(); readout = 1'b1; step(); readout = 1'b0;
        w = 0;
        for (int k = 0; k < 4; k++) begin if (out_valid) w++; step(); end
        pat = N'(64'h0000_0000_0000_5000);
        disc = pat; step(); step(); disc = '0;
        if (out_valid) w++;
        chk(w == 0, "R12 no beats in window", w, 0);
        stop = 1'b1; step(); stop = 1'b0;
        run_readout(1'b0, 1'b0);
        verify(pat, "R12 late hits");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule